// File: doc/BRIEF.md
# Cross-Clock One-Word Mailbox with Bus-Width Matching

This block is a single-entry message register that lets the port B side of a two-clock buffer hand a short message to the port A side without passing it through the data queue. Port B writes the register in its own clock domain; port A reads it in a separate, unrelated clock domain. An active-low "message waiting" flag in the port A domain tells the reader that an unread message is held.

The number of bits port B stores depends on the bus size that port B is set to: a 36-bit long word, an 18-bit word or a 9-bit byte. Bits above the chosen width are dropped at write time and read as zero on port A. Port A's 36-bit output is shared with the queue's output register. A select input picks which of the two is shown. The flag crosses between the domains with a toggle handshake: a request toggle is synchronised into the port A clock, and an acknowledge toggle is synchronised back into the port B clock. Port B cannot write again until the acknowledge has returned, so an unread message is never overwritten.

Top module: `mbx_dual_port`

## Requirements
- R1: Port B stores a message on a rising `clk_b` edge only when all four of these hold: `b_cs_n`=0, `b_dir`=1 (write), `b_en`=1 and `b_mbx_sel`=1. If any one of them is missing, the register and the flag are unchanged.
- R2: With `b_bus_size`=2'b00 (long) or 2'b11 (reserved, treated as long), all 36 bits of `b_data` are stored.
- R3: With `b_bus_size`=2'b01 (word), only `b_data[17:0]` is stored. Port A reads bits 35:18 as zero.
- R4: With `b_bus_size`=2'b10 (byte), only `b_data[8:0]` is stored. Port A reads bits 35:9 as zero.
- R5: `a_data` equals `fifo_q` while `a_mbx_sel`=0, and equals the stored message while `a_mbx_sel`=1.
- R6: After an accepted port B write, `mbx_full_n` goes low after the second rising `clk_a` edge that follows the write edge (two-flop synchroniser).
- R7: A port A read strobe (`a_cs_n`=0, `a_dir`=0, `a_en`=1, `a_mbx_sel`=1) taken on a rising `clk_a` edge while `mbx_full_n`=0 sets `mbx_full_n` high after that edge.
- R8: The stored message stays readable on port A after it has been read, until port B writes a new one.
- R9: A port B write strobe is ignored while a message is unread or its acknowledge has not yet returned to the port B domain. The held message is unchanged.
- R10: While `rst_n` is low at a clock edge (synchronous, active low), the register clears to zero and `mbx_full_n` goes high.
- R11: A port A read strobe while `mbx_full_n`=1 has no effect: the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A (reader) clock |
| clk_b | input | 1 | Port B (writer) clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_dir | input | 1 | Port B direction, 1 = write |
| b_en | input | 1 | Port B enable |
| b_mbx_sel | input | 1 | Port B targets the mailbox when high |
| b_bus_size | input | 2 | Port B bus size: 00 long, 01 word, 10 byte, 11 long |
| b_data | input | 36 | Port B write data |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_dir | input | 1 | Port A direction, 0 = read |
| a_en | input | 1 | Port A enable |
| a_mbx_sel | input | 1 | Port A output select: 1 mailbox, 0 queue output |
| fifo_q | input | 36 | Queue output register value |
| a_data | output | 36 | Port A data output |
| mbx_full_n | output | 1 | Message-waiting flag, active low, port A domain |

## Verification
On every cycle, the assertions check these properties: the flag clears after a read, reset forces the flag high, the register holds still whenever no write is accepted or the flag shows a message, word writes leave the upper bits zero, and the output select follows `a_mbx_sel`. The exact two-edge flag latency, the masking in every bus size over a sweep of data patterns, the rejection of each incomplete strobe combination, and the preservation of an unread message against a second write can only be shown by the bench's scenarios. Each of these scenarios compares the port A output with values computed from the written data.

// File: rtl/mbx_pkg.sv
// Package: shared types and helpers for the cross-clock mailbox.
// Assumes a port B bus size code of two bits; 2'b11 is treated as long.
package mbx_pkg;

    typedef enum logic [1:0] {
        BUS_LONG = 2'b00,
        BUS_WORD = 2'b01,
        BUS_BYTE = 2'b10,
        BUS_RSVD = 2'b11
    } bus_size_e;

    // Number of stored bits for a given bus size code.
    function automatic int unsigned kept_bits(input logic [1:0] code,
                                              input int unsigned full_w,
                                              input int unsigned word_w,
                                              input int unsigned byte_w);
        case (code)
            BUS_WORD: kept_bits = word_w;
            BUS_BYTE: kept_bits = byte_w;
            default:  kept_bits = full_w;
        endcase
    endfunction

endpackage

// File: rtl/mbx_width_mask.sv
// Module: mbx_width_mask
// Clears every data bit above the width chosen by the bus size code.
// Assumes BYTE_W <= WORD_W <= DATA_W. Purely combinational.
module mbx_width_mask
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned WORD_W = 18,
    parameter int unsigned BYTE_W = 9
) (
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic keep_word;
    logic keep_long;

    // Decode which bit bands survive for the current bus size.
    always_comb begin
        keep_long = (bus_size == BUS_LONG) || (bus_size == BUS_RSVD);
        keep_word = keep_long || (bus_size == BUS_WORD);
    end

    // One gate per bit, chosen by the band the bit falls in.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < BYTE_W) begin : g_byte_band
            assign dout[i] = din[i];
        end else if (i < WORD_W) begin : g_word_band
            assign dout[i] = din[i] & keep_word;
        end else begin : g_long_band
            assign dout[i] = din[i] & keep_long;
        end
    end

endmodule

// File: rtl/mbx_toggle_sync.sv
// Module: mbx_toggle_sync
// Multi-flop synchroniser for a single toggle signal into clk's domain.
// Assumes the input changes at most once per several destination cycles.
module mbx_toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous toggle through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mbx_write_side.sv
// Module: mbx_write_side
// Port B domain: decodes the write strobe, masks and stores the message,
// flips the request toggle and blocks writes until the acknowledge returns.
// Assumes ack_tgl comes from the port A domain (asynchronous).
module mbx_write_side #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned WORD_W = 18,
    parameter int unsigned BYTE_W = 9,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              b_cs_n,
    input  logic              b_dir,
    input  logic              b_en,
    input  logic              b_mbx_sel,
    input  logic [1:0]        b_bus_size,
    input  logic [DATA_W-1:0] b_data,
    input  logic              ack_tgl,
    output logic              req_tgl,
    output logic              wr_accept,
    output logic [DATA_W-1:0] mbx_q
);

    logic              ack_seen;
    logic              busy;
    logic              wr_strobe;
    logic [DATA_W-1:0] masked;

    mbx_toggle_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk_b),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_seen)
    );

    mbx_width_mask #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_mask (
        .bus_size (b_bus_size),
        .din      (b_data),
        .dout     (masked)
    );

    // Decode the strobe and refuse it while a handshake is open.
    always_comb begin
        wr_strobe = !b_cs_n && b_dir && b_en && b_mbx_sel;
        busy      = (req_tgl != ack_seen);
        wr_accept = wr_strobe && !busy;
    end

    // Store the masked message and open a new handshake.
    always_ff @(posedge clk_b) begin
        if (!rst_n) begin
            mbx_q   <= '0;
            req_tgl <= 1'b0;
        end else if (wr_accept) begin
            mbx_q   <= masked;
            req_tgl <= ~req_tgl;
        end
    end

endmodule

// File: rtl/mbx_read_side.sv
// Module: mbx_read_side
// Port A domain: synchronises the request toggle, derives the full flag
// and answers a read with the acknowledge toggle.
// Assumes req_tgl comes from the port B domain (asynchronous).
module mbx_read_side #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_a,
    input  logic rst_n,
    input  logic a_cs_n,
    input  logic a_dir,
    input  logic a_en,
    input  logic a_mbx_sel,
    input  logic req_tgl,
    output logic ack_tgl,
    output logic full
);

    logic req_seen;
    logic rd_accept;

    mbx_toggle_sync #(.STAGES(STAGES)) u_req_sync (
        .clk   (clk_a),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_seen)
    );

    // A message is held while the request has not been answered.
    always_comb begin
        full      = (req_seen != ack_tgl);
        rd_accept = !a_cs_n && !a_dir && a_en && a_mbx_sel && full;
    end

    // Answer an accepted read by flipping the acknowledge toggle.
    always_ff @(posedge clk_a) begin
        if (!rst_n) begin
            ack_tgl <= 1'b0;
        end else if (rd_accept) begin
            ack_tgl <= ~ack_tgl;
        end
    end

endmodule

// File: rtl/mbx_dual_port.sv
// Module: mbx_dual_port
// Top of the cross-clock mailbox: port B writes, port A reads, and the
// port A output is shared between the mailbox and the queue output.
// Assumes clk_a and clk_b are unrelated; rst_n is seen by both domains.
module mbx_dual_port #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned WORD_W = 18,
    parameter int unsigned BYTE_W = 9,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst_n,
    input  logic              b_cs_n,
    input  logic              b_dir,
    input  logic              b_en,
    input  logic              b_mbx_sel,
    input  logic [1:0]        b_bus_size,
    input  logic [DATA_W-1:0] b_data,
    input  logic              a_cs_n,
    input  logic              a_dir,
    input  logic              a_en,
    input  logic              a_mbx_sel,
    input  logic [DATA_W-1:0] fifo_q,
    output logic [DATA_W-1:0] a_data,
    output logic              mbx_full_n
);

    logic              req_tgl;
    logic              ack_tgl;
    logic              wr_accept;
    logic              full;
    logic [DATA_W-1:0] mbx_q;

    mbx_write_side #(
        .DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .STAGES(STAGES)
    ) u_bside (
        .clk_b      (clk_b),
        .rst_n      (rst_n),
        .b_cs_n     (b_cs_n),
        .b_dir      (b_dir),
        .b_en       (b_en),
        .b_mbx_sel  (b_mbx_sel),
        .b_bus_size (b_bus_size),
        .b_data     (b_data),
        .ack_tgl    (ack_tgl),
        .req_tgl    (req_tgl),
        .wr_accept  (wr_accept),
        .mbx_q      (mbx_q)
    );

    mbx_read_side #(.STAGES(STAGES)) u_aside (
        .clk_a     (clk_a),
        .rst_n     (rst_n),
        .a_cs_n    (a_cs_n),
        .a_dir     (a_dir),
        .a_en      (a_en),
        .a_mbx_sel (a_mbx_sel),
        .req_tgl   (req_tgl),
        .ack_tgl   (ack_tgl),
        .full      (full)
    );

    // Share the port A output and present the flag active low.
    always_comb begin
        a_data     = a_mbx_sel ? mbx_q : fifo_q;
        mbx_full_n = !full;
    end

endmodule

// File: rtl/mbx_dual_port_chk.sv
// Module: mbx_dual_port_chk
// Property checker for mbx_dual_port, attached by the bind below.
module mbx_dual_port_chk #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned WORD_W = 18
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst_n,
    input logic [1:0]        b_bus_size,
    input logic              a_cs_n,
    input logic              a_dir,
    input logic              a_en,
    input logic              a_mbx_sel,
    input logic [DATA_W-1:0] fifo_q,
    input logic [DATA_W-1:0] a_data,
    input logic              mbx_full_n,
    input logic              wr_accept,
    input logic [DATA_W-1:0] mbx_q
);

    // R7
    read_clears_flag_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!a_cs_n && !a_dir && a_en && a_mbx_sel && !mbx_full_n) |=> mbx_full_n);

    // R10
    reset_flag_high_chk: assert property (@(posedge clk_a)
        !rst_n |=> mbx_full_n);

    // R1
    no_write_hold_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !wr_accept |=> $stable(mbx_q));

    // R3
    word_upper_zero_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        (wr_accept && b_bus_size == 2'b01) |=> (mbx_q[DATA_W-1:WORD_W] == '0));

    // R9
    full_holds_msg_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!mbx_full_n && $past(!mbx_full_n) && a_mbx_sel && $past(a_mbx_sel))
        |-> $stable(a_data));

    // R5
    fifo_path_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !a_mbx_sel |-> (a_data == fifo_q));

endmodule

bind mbx_dual_port mbx_dual_port_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
    .clk_a      (clk_a),
    .clk_b      (clk_b),
    .rst_n      (rst_n),
    .b_bus_size (b_bus_size),
    .a_cs_n     (a_cs_n),
    .a_dir      (a_dir),
    .a_en       (a_en),
    .a_mbx_sel  (a_mbx_sel),
    .fifo_q     (fifo_q),
    .a_data     (a_data),
    .mbx_full_n (mbx_full_n),
    .wr_accept  (wr_accept),
    .mbx_q      (mbx_q)
);

// File: tb/sim_mbx_dual_port.sv
// Bench for mbx_dual_port: sweeps bus sizes, data patterns and strobe
// combinations; expected values come from masking arithmetic.
module sim_mbx_dual_port;

    localparam int CLK_A_PERIOD = 10;
    localparam int CLK_B_PERIOD = 14;
    localparam int DW           = 36;
    localparam int WATCHDOG     = 50000;

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          rst_n = 1'b0;
    logic          b_cs_n = 1'b1, b_dir = 1'b0, b_en = 1'b0, b_mbx_sel = 1'b0;
    logic [1:0]    b_bus_size = 2'b00;
    logic [DW-1:0] b_data = '0;
    logic          a_cs_n = 1'b1, a_dir = 1'b1, a_en = 1'b0, a_mbx_sel = 1'b1;
    logic [DW-1:0] fifo_q = '0;
    logic [DW-1:0] a_data;
    logic          mbx_full_n;

    int checks = 0;
    int fails  = 0;
    int a_cycles = 0;
    bit done = 1'b0;

    mbx_dual_port u0 (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .b_cs_n(b_cs_n), .b_dir(b_dir), .b_en(b_en), .b_mbx_sel(b_mbx_sel),
        .b_bus_size(b_bus_size), .b_data(b_data),
        .a_cs_n(a_cs_n), .a_dir(a_dir), .a_en(a_en), .a_mbx_sel(a_mbx_sel),
        .fifo_q(fifo_q), .a_data(a_data), .mbx_full_n(mbx_full_n)
    );

    always #(CLK_A_PERIOD/2) clk_a = ~clk_a;
    initial begin
        #3;
        forever #(CLK_B_PERIOD/2) clk_b = ~clk_b;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk_a) begin
        a_cycles <= a_cycles + 1;
        if (a_cycles > WATCHDOG && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog all-reqs cycles=%0d expected<=%0d", a_cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expect_mask(input logic [1:0] sz, input logic [DW-1:0] d);
        if (sz == 2'b01) return d & ((36'd1 << 18) - 36'd1);
        if (sz == 2'b10) return d & ((36'd1 << 9) - 36'd1);
        return d;
    endfunction

    // Apply one port B strobe and count clk_a edges until the flag drops.
    task automatic b_strobe(input logic cs_n, input logic dir, input logic en,
                            input logic sel, input logic [1:0] sz,
                            input logic [DW-1:0] d, output int lat);
        @(negedge clk_b);
        b_cs_n = cs_n; b_dir = dir; b_en = en; b_mbx_sel = sel;
        b_bus_size = sz; b_data = d;
        @(posedge clk_b);
        lat = 0;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk_a); #1;
            lat = lat + 1;
            if (!mbx_full_n) break;
        end
        @(negedge clk_b);
        b_cs_n = 1'b1; b_dir = 1'b0; b_en = 1'b0; b_mbx_sel = 1'b0;
    endtask

    task automatic a_read();
        @(negedge clk_a);
        a_cs_n = 1'b0; a_dir = 1'b0; a_en = 1'b1; a_mbx_sel = 1'b1;
        @(posedge clk_a); #1;
        @(negedge clk_a);
        a_cs_n = 1'b1; a_dir = 1'b1; a_en = 1'b0;
    endtask

    task automatic settle_b();
        repeat (6) @(posedge clk_b);
        @(negedge clk_a);
    endtask

    initial begin
        int lat;
        logic [DW-1:0] held;
        logic [DW-1:0] pat;
        logic [DW-1:0] exp;

        repeat (4) @(posedge clk_b);
        @(negedge clk_a);
        // R10: reset state
        check("R10 flag", {35'd0, mbx_full_n}, 36'd1);
        check("R10 data", a_data, '0);
        rst_n = 1'b1;
        settle_b();

        // R1: every incomplete strobe combination is ignored
        for (int c = 0; c < 16; c++) begin
            if (c == 4'b0111) continue;
            b_strobe(c[3], c[2], c[1], c[0], 2'b00, 36'hA_5A5A_5A5A, lat);
            repeat (3) @(posedge clk_a);
            #1;
            check("R1 flag", {35'd0, mbx_full_n}, 36'd1);
            check("R1 data", a_data, '0);
        end

        // R2 R3 R4 R5 R6 R7 R8: sweep bus sizes and data patterns
        for (int sz = 0; sz < 4; sz++) begin
            for (int i = 0; i < 6; i++) begin
                pat = (i == 0) ? 36'hF_FFFF_FFFF
                               : ((36'h9_E377_9B97 * i) ^ (36'h5_5555_5555 >> i));
                exp = expect_mask(sz[1:0], pat);
                b_strobe(1'b0, 1'b1, 1'b1, 1'b1, sz[1:0], pat, lat);
                check("R6 latency", 36'(lat), 36'd2);
                if (sz == 1)      check("R3 word", a_data, exp);
                else if (sz == 2) check("R4 byte", a_data, exp);
                else              check("R2 long", a_data, exp);
                @(negedge clk_a);
                a_mbx_sel = 1'b0; fifo_q = ~pat;
                #1;
                check("R5 fifo path", a_data, ~pat);
                a_mbx_sel = 1'b1;
                #1;
                check("R5 mbx path", a_data, exp);
                a_read();
                check("R7 flag", {35'd0, mbx_full_n}, 36'd1);
                check("R8 held", a_data, exp);
                settle_b();
                held = exp;
            end
        end

        // R9: second write while a message is unread is dropped
        b_strobe(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 36'h1_2345_6789, lat);
        b_strobe(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 36'hE_DCBA_9876, lat);
        repeat (4) @(posedge clk_a);
        #1;
        check("R9 data", a_data, 36'h1_2345_6789);
        check("R9 flag", {35'd0, mbx_full_n}, 36'd0);
        a_read();
        settle_b();
        check("R9 after read", a_data, 36'h1_2345_6789);

        // R11: read while nothing waits leaves the flag high
        a_read();
        check("R11 flag", {35'd0, mbx_full_n}, 36'd1);
        repeat (4) @(posedge clk_a);
        #1;
        check("R11 flag later", {35'd0, mbx_full_n}, 36'd1);
        check("R11 data", a_data, 36'h1_2345_6789);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule